// File: doc/BRIEF.md
# Five-Level Third-Order Noise Shaper

This block turns an oversampled stream of signed PCM words into a five-level code for a multi-level DAC. Words arrive at eight times the audio sample rate, each one marked by a one-cycle strobe. The modulator clock runs six or eight times faster than that word rate, which corresponds to 48 or 64 times the sample rate. A rate-select input sets how many modulator cycles each captured word stays in use.

Inside is a third-order loop built from three integrators, each with a unit delay. The quantizer output is fed back into every integrator. Loop gains are fixed at design time and are made only from shifts and adds. Every integrator clamps at its limits instead of wrapping. The quantizer reads the last integrator and produces a level from 0 to 4. Level 2 stands for a zero feedback value.

A synchronous reset clears the whole loop. A separate force input holds the output at midscale and restarts the loop from empty states.

Top module: `ns5_modulator`

## Requirements
- R1: On each clock edge, with x the effective input and v the feedback value, the integrators update from their pre-edge values as follows: a ← a + x − v, b ← b + a − 6v, c ← c + b − 12v.
- R2: `level_out` is computed from integrator c with S = 2^(DW−2). The level is 0 when c < −12S, 1 when c < −4S, 2 when c < 4S, 3 when c < 12S, and 4 otherwise. The level never exceeds 4.
- R3: The feedback value is v = (level − 2)·S. It uses the quantizer level taken from c before any forcing is applied, so the five values are evenly spaced and level 2 gives zero.
- R4: A strobe captures `smp_data` as a DW-bit two's-complement word. That word is the effective input for the next 6 edges when `slow_ratio` is 0, or the next 8 edges when it is 1. After that window ends with no new strobe, the effective input is zero.
- R5: A strobe that arrives inside a running window replaces the held word and starts a full new window.
- R6: While `rst` is high at an edge, the integrators, the held word and the window are cleared, so `level_out` reads 2 after that edge.
- R7: While `mid_force` is high, `level_out` is 2 in the same cycle and every edge clears the three integrators. Strobe capture and window counting carry on during this time.
- R8: Each integrator is DW+GUARD bits wide (24 by default). A sum above 2^23−1 or below −2^23 is clamped to that limit.
- R9: A loop started from reset with no strobes stays at level 2 on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_stb | input | 1 | One-cycle strobe marking a new input word |
| smp_data | input | DW | Signed oversampled input word |
| slow_ratio | input | 1 | Hold window select: 0 for 6 cycles, 1 for 8 cycles |
| mid_force | input | 1 | Holds the output at level 2 and clears the integrators |
| level_out | output | 3 | Quantizer level, 0 to 4 |

## Verification
The case that needs care is when a new word strobe lands in a cycle where midscale forcing is also active. The integrators must clear, yet the word must still be captured and its window must still start counting. The bench provokes this by raising the strobe and the force together and dropping the force one cycle later. It then compares every following level with a model started from cleared integrators and holding that captured word. A strobe that lands while an older window is still running is handled the same way.

// File: rtl/ns5_modulator.sv
module ns5_modulator #(
  parameter int DW     = 18,
  parameter int GUARD  = 6,
  parameter int HOLD_A = 6,
  parameter int HOLD_B = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_stb,
  input  logic signed [DW-1:0] smp_data,
  input  logic                 slow_ratio,
  input  logic                 mid_force,
  output logic [2:0]           level_out
);
  localparam int IW = DW + GUARD;
  localparam int SW = IW + 4;
  localparam int HMAX = (HOLD_A > HOLD_B) ? HOLD_A : HOLD_B;
  localparam int CW = $clog2(HMAX + 1);

  localparam logic signed [SW-1:0] STEP = {{(SW-DW+1){1'b0}}, 1'b1, {(DW-2){1'b0}}};
  localparam logic signed [SW-1:0] TA   = STEP <<< 2;
  localparam logic signed [SW-1:0] TB   = (STEP <<< 3) + (STEP <<< 2);
  localparam logic signed [SW-1:0] HI   = {{(SW-IW+1){1'b0}}, {(IW-1){1'b1}}};
  localparam logic signed [SW-1:0] LO   = {{(SW-IW+1){1'b1}}, {(IW-1){1'b0}}};

  logic signed [IW-1:0] ia, ib, ic;
  logic signed [DW-1:0] x_hold;
  logic [CW-1:0]        win;
  logic [2:0]           q;
  logic signed [SW-1:0] cw, xe, v, v6, v12;

  function automatic logic signed [IW-1:0] clip(input logic signed [SW-1:0] s);
    if (s > HI) return HI[IW-1:0];
    if (s < LO) return LO[IW-1:0];
    return s[IW-1:0];
  endfunction

  assign cw = SW'(ic);

  always_comb begin
    if (cw < -TB)      q = 3'd0;
    else if (cw < -TA) q = 3'd1;
    else if (cw < TA)  q = 3'd2;
    else if (cw < TB)  q = 3'd3;
    else               q = 3'd4;
  end

  always_comb begin
    case (q)
      3'd0:    v = -(STEP + STEP);
      3'd1:    v = -STEP;
      3'd2:    v = '0;
      3'd3:    v = STEP;
      default: v = STEP + STEP;
    endcase
  end

  assign v6  = (v <<< 2) + (v <<< 1);
  assign v12 = (v <<< 3) + (v <<< 2);
  assign xe  = (win != '0) ? SW'(x_hold) : '0;

  always_ff @(posedge clk) begin
    if (rst || mid_force) begin
      ia <= '0;
      ib <= '0;
      ic <= '0;
    end else begin
      ia <= clip(SW'(ia) + xe - v);
      ib <= clip(SW'(ib) + SW'(ia) - v6);
      ic <= clip(SW'(ic) + SW'(ib) - v12);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      x_hold <= '0;
      win    <= '0;
    end else if (smp_stb) begin
      x_hold <= smp_data;
      win    <= slow_ratio ? CW'(HOLD_B) : CW'(HOLD_A);
    end else if (win != '0) begin
      win <= win - CW'(1);
    end
  end

  assign level_out = mid_force ? 3'd2 : q;
endmodule

module ns5_modulator_chk (
  input logic       clk,
  input logic       rst,
  input logic       mid_force,
  input logic [2:0] level_out
);
  a_r2_level_range: assert property (@(posedge clk) disable iff (rst)
    level_out <= 3'd4);

  a_r7_force_mid: assert property (@(posedge clk) disable iff (rst)
    mid_force |-> level_out == 3'd2);

  a_r7_force_release: assert property (@(posedge clk) disable iff (rst)
    ($past(mid_force) && !mid_force) |-> level_out == 3'd2);

  a_r6_reset_mid: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> level_out == 3'd2);
endmodule

bind ns5_modulator ns5_modulator_chk u_chk (
  .clk(clk), .rst(rst), .mid_force(mid_force), .level_out(level_out)
);

// File: tb/ns5_modulator_bench.sv
module ns5_modulator_bench;
  localparam int DW = 18;
  localparam int IW = DW + 6;
  localparam longint S = longint'(1) << (DW - 2);

  logic clk = 1'b0, rst = 1'b1, smp_stb = 1'b0, slow_ratio = 1'b0, mid_force = 1'b0;
  logic signed [DW-1:0] smp_data = '0;
  logic [2:0] level_out;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  longint m1 = 0, m2 = 0, m3 = 0, mx = 0;
  int mcnt = 0;

  ns5_modulator u_ns5_modulator (
    .clk(clk), .rst(rst), .smp_stb(smp_stb), .smp_data(smp_data),
    .slow_ratio(slow_ratio), .mid_force(mid_force), .level_out(level_out)
  );

  always #2 clk = ~clk;

  function automatic int mq(longint c);
    if (c < -12 * S) return 0;
    if (c < -4 * S)  return 1;
    if (c < 4 * S)   return 2;
    if (c < 12 * S)  return 3;
    return 4;
  endfunction

  function automatic longint msat(longint s);
    longint hi = (longint'(1) << (IW - 1)) - 1;
    longint lo = -(longint'(1) << (IW - 1));
    if (s > hi) return hi;
    if (s < lo) return lo;
    return s;
  endfunction

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: level_out=%0d expected=%0d at %0t", req, got, exp, $time);
    end
  endtask

  task automatic tick(bit stb, longint d, bit rate, bit frc, bit r);
    longint v, xe, n1, n2, n3;
    smp_stb = stb; smp_data = DW'(d); slow_ratio = rate; mid_force = frc; rst = r;
    if (r) begin
      m1 = 0; m2 = 0; m3 = 0; mx = 0; mcnt = 0;
    end else begin
      v  = longint'(mq(m3) - 2) * S;
      xe = (mcnt != 0) ? mx : 0;
      if (frc) begin
        n1 = 0; n2 = 0; n3 = 0;
      end else begin
        n1 = msat(m1 + xe - v);
        n2 = msat(m2 + m1 - 6 * v);
        n3 = msat(m3 + m2 - 12 * v);
      end
      m1 = n1; m2 = n2; m3 = n3;
      if (stb) begin
        mx = d; mcnt = rate ? 8 : 6;
      end else if (mcnt != 0) begin
        mcnt--;
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic step(string req, bit stb, longint d, bit rate, bit frc);
    tick(stb, d, rate, frc, 1'b0);
    check(req, int'(level_out), frc ? 2 : mq(m3));
  endtask

  task automatic t_reset();
    tick(0, 0, 0, 0, 1);
    tick(0, 0, 0, 0, 1);
    check("R6 reset level", int'(level_out), 2);
    for (int i = 0; i < 24; i++) begin
      tick(0, 0, 0, 0, 0);
      check("R9 idle after reset", int'(level_out), 2);
    end
  endtask

  task automatic t_dc(string req, bit rate, longint val, int cyc);
    int hold = rate ? 8 : 6;
    for (int c = 0; c < cyc; c++) step(req, (c % hold) == 0, val, rate, 0);
  endtask

  task automatic t_wave();
    for (int c = 0; c < 640; c++)
      step("R4 R1 slow ratio wave", (c % 8) == 0, longint'(((c / 8) % 32) - 16) * 6000, 1, 0);
  endtask

  task automatic t_starve();
    step("R4 starve", 1, 100000, 0, 0);
    for (int c = 0; c < 60; c++) step("R4 window expiry", 0, 0, 0, 0);
  endtask

  task automatic t_restart();
    for (int c = 0; c < 120; c++)
      step("R5 restart window", (c % 3) == 0, (c % 6 == 0) ? 90000 : -30000, 0, 0);
  endtask

  task automatic t_force();
    t_dc("R3 before force", 0, 70000, 36);
    for (int c = 0; c < 10; c++) begin
      step("R7 force holds", 0, 0, 0, 1);
      check("R7 force literal", int'(level_out), 2);
    end
    for (int c = 0; c < 10; c++) begin
      step("R7 release empty", 0, 0, 0, 0);
      check("R7 cleared loop", int'(level_out), 2);
    end
  endtask

  task automatic t_force_strobe();
    step("R7 strobe under force", 1, -90000, 1, 1);
    for (int c = 1; c < 200; c++) step("R7 R4 after force strobe", (c % 8) == 0, -90000, 1, 0);
  endtask

  task automatic t_overload();
    t_dc("R8 positive full scale", 0, 131071, 300);
    t_dc("R8 negative full scale", 0, -131072, 300);
    t_dc("R8 step back", 1, 131071, 200);
  endtask

  task automatic t_midreset();
    t_dc("R2 run", 0, -50000, 30);
    tick(0, 0, 0, 0, 1);
    check("R6 reset mid run", int'(level_out), 2);
    for (int c = 0; c < 12; c++) step("R6 idle after reset", 0, 0, 0, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_dc("R1 R2 dc positive", 0, 40000, 240);
    t_dc("R1 R3 dc negative", 0, -70000, 240);
    t_wave();
    t_starve();
    t_restart();
    t_force();
    t_force_strobe();
    t_overload();
    t_midreset();
    finish_run();
  end

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: run did not end, actual=running expected=done");
    finish_run();
  end
endmodule